// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is one timer channel built around a 16-bit down counter. It steps once on every rising edge of `clk`. A control write picks one of six waveform behaviours and chooses binary or decimal (BCD) counting. A separate count write supplies the initial value N and arms the channel. The block does not decode a bus. The host side drives the two write strobes directly. The block does not read back status either. Only the live counter value is visible, on `count`.

The input `run_ctl` has a different meaning in each behaviour. In the delay, rate and square-wave behaviours it is a level enable, and while it is low the counter holds its value. In the one-shot and hardware-strobe behaviours, a rising edge on it is a trigger. In the software strobe it is ignored. The output `wave_out` carries the result: a terminal-count step, a gated low pulse, a periodic one-clock dip, a square wave or a single-clock strobe.

Top module: `interval_counter_channel`

## Requirements
- R1: After reset `wave_out` is 1 and `count` is 0. A control write disarms the channel and sets `wave_out` to 0 in behaviour 0 and to 1 in every other behaviour. Until a count is written, neither `count` nor `wave_out` changes. This holds even when `run_ctl` toggles.
- R2: In binary mode the counter falls by exactly one per enabled clock. A count of 0 stands for 65536, so after one step the counter reads 0xFFFF.
- R3: When `ctl_bcd` is 1, the counter steps through four BCD digits with borrow between them, and every digit stays at 9 or below. 0x0000 steps to 0x9999, 0x0100 steps to 0x0099, and a count of 0 stands for 10000.
- R4: The value on `ctl_mode` selects the behaviour: 0 delay, 1 one-shot, 2 rate, 3 square, 4 software strobe, 5 hardware strobe. Value 6 acts as 2 and value 7 acts as 3.
- R5: Delay (0): the count write loads N on that edge and drives `wave_out` low. `wave_out` rises on the Nth enabled clock after the load and then stays high. While `run_ctl` is low, both `count` and `wave_out` hold.
- R6: One-shot (1): a count write only arms the channel. On the first edge that sees `run_ctl` rise, the counter reloads with the latest count and `wave_out` goes low for exactly N clocks. A count written during a pulse does not change that pulse. A new rising edge restarts the pulse with the latest count. Pulses repeat on later rising edges without a new count write.
- R7: Rate (2), N ≥ 2: `wave_out` is low for one clock in every N clocks. It is low on the clock whose count is 1. The next clock reloads N. A count written while the channel runs takes effect at the next reload. While `run_ctl` is low, the counter holds.
- R8: Square (3), N ≥ 2: the period is N clocks. `wave_out` is high for ceil(N/2) clocks, starting at each load or reload, and low for floor(N/2) clocks. With a count of 0 the period is 65536 in binary mode and 10000 in BCD mode.
- R9: Software strobe (4): the count write loads N with `wave_out` high. `wave_out` is low only on the Nth clock after the load, and after that clock it stays high. `run_ctl` has no effect.
- R10: Hardware strobe (5): a count write only arms the channel. Each rising edge of `run_ctl` reloads the counter. `wave_out` is low only on the Nth clock after that edge. The sequence repeats on the next rising edge without a new count write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Count clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control write strobe; takes priority over `cnt_wr` |
| ctl_mode | input | 3 | Behaviour select (R4) |
| ctl_bcd | input | 1 | 1 selects BCD counting |
| cnt_wr | input | 1 | Count write strobe |
| cnt_in | input | 16 | Initial count N |
| run_ctl | input | 1 | Level enable or edge trigger, depending on behaviour |
| wave_out | output | 1 | Waveform output |
| count | output | 16 | Current counter value |

## Verification
A wrong counter value shows on `count` on the very next clock. In the periodic behaviours it also moves the `wave_out` dip or phase change by whole clocks, so a sweep of N from 2 to about 11 exposes it within one or two periods. A stuck enable, arm or run flag shows as a pulse that never ends, never starts or lasts one clock too long. That appears within N + 1 clocks of the trigger or the load. A BCD borrow error shows at the first digit rollover, which is why single-step checks are made from 0x0000, 0x0100 and 0x0010. A wrong half-period split shows as a high count that is off by one over a full square-wave period.

// File: rtl/interval_counter_channel.sv
module interval_counter_channel (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_wr,
  input  logic [2:0]  ctl_mode,
  input  logic        ctl_bcd,
  input  logic        cnt_wr,
  input  logic [15:0] cnt_in,
  input  logic        run_ctl,
  output logic        wave_out,
  output logic [15:0] count
);
  logic [2:0]  mode_q;
  logic        bcd_q, armed, run, rc_q, out_q;
  logic [15:0] cnt_q, init_q, dec;
  logic [16:0] ph_q, len, hi, bcd_bin;
  logic [2:0]  mode_n;
  logic        rise, edge_mode, lvl_mode, load_now, fire, en;

  function automatic logic [15:0] bcd_dec(input logic [15:0] v);
    logic [15:0] r;
    logic        brw;
    r   = v;
    brw = 1'b1;
    for (int i = 0; i < 4; i++) begin
      if (brw) begin
        if (r[4*i +: 4] == 4'd0) r[4*i +: 4] = 4'd9;
        else begin
          r[4*i +: 4] = r[4*i +: 4] - 4'd1;
          brw = 1'b0;
        end
      end
    end
    return r;
  endfunction

  assign dec     = bcd_q ? bcd_dec(cnt_q) : cnt_q - 16'd1;
  assign bcd_bin = 17'(init_q[15:12]) * 17'd1000 + 17'(init_q[11:8]) * 17'd100
                 + 17'(init_q[7:4]) * 17'd10 + 17'(init_q[3:0]);
  assign len     = (init_q == 16'd0) ? (bcd_q ? 17'd10000 : 17'd65536)
                                     : (bcd_q ? bcd_bin : {1'b0, init_q});
  assign hi      = (len + 17'd1) >> 1;

  assign mode_n    = (ctl_mode[2:1] == 2'b11) ? {1'b0, ctl_mode[1:0]} : ctl_mode;
  assign rise      = run_ctl & ~rc_q;
  assign edge_mode = (mode_q == 3'd1) || (mode_q == 3'd5);
  assign lvl_mode  = (mode_q == 3'd0) || (mode_q == 3'd2) || (mode_q == 3'd3);
  assign load_now  = cnt_wr && ((mode_q == 3'd0) || (mode_q == 3'd4) ||
                                (((mode_q == 3'd2) || (mode_q == 3'd3)) && !armed));
  assign fire      = edge_mode && armed && rise;
  assign en        = run && (run_ctl || !lvl_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 3'd0;
      bcd_q  <= 1'b0;
      armed  <= 1'b0;
      run    <= 1'b0;
      rc_q   <= 1'b0;
      out_q  <= 1'b1;
      cnt_q  <= 16'd0;
      init_q <= 16'd0;
      ph_q   <= 17'd0;
    end else begin
      rc_q <= run_ctl;
      if (ctl_wr) begin
        mode_q <= mode_n;
        bcd_q  <= ctl_bcd;
        armed  <= 1'b0;
        run    <= 1'b0;
        out_q  <= (mode_n != 3'd0);
      end else begin
        if (cnt_wr) begin
          init_q <= cnt_in;
          armed  <= 1'b1;
        end
        if (load_now) begin
          cnt_q <= cnt_in;
          ph_q  <= 17'd0;
          run   <= 1'b1;
          out_q <= (mode_q != 3'd0);
        end else if (fire) begin
          cnt_q <= init_q;
          run   <= 1'b1;
          out_q <= (mode_q == 3'd5);
        end else if (en) begin
          case (mode_q)
            3'd0: begin
              cnt_q <= dec;
              if (dec == 16'd0) out_q <= 1'b1;
            end
            3'd1: begin
              cnt_q <= dec;
              if (dec == 16'd0) begin
                out_q <= 1'b1;
                run   <= 1'b0;
              end
            end
            3'd2: begin
              if (cnt_q == 16'd1) begin
                cnt_q <= init_q;
                out_q <= 1'b1;
              end else begin
                cnt_q <= dec;
                out_q <= (dec != 16'd1);
              end
            end
            3'd3: begin
              if (cnt_q == 16'd1) begin
                cnt_q <= init_q;
                ph_q  <= 17'd0;
                out_q <= 1'b1;
              end else begin
                cnt_q <= dec;
                ph_q  <= ph_q + 17'd1;
                out_q <= ((ph_q + 17'd1) < hi);
              end
            end
            default: begin
              if (!out_q) begin
                out_q <= 1'b1;
                run   <= 1'b0;
              end else begin
                cnt_q <= dec;
                if (dec == 16'd0) out_q <= 1'b0;
              end
            end
          endcase
        end
      end
    end
  end

  assign wave_out = out_q;
  assign count    = cnt_q;

  AST_IDLE_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !cnt_wr && !ctl_wr) |=> ($stable(count) && $stable(wave_out)));  // R1
  AST_BCD_DIGITS: assert property (@(posedge clk) disable iff (!rst_n)
    (bcd_q && run) |-> (count[3:0] <= 4'd9 && count[7:4] <= 4'd9 &&
                        count[11:8] <= 4'd9 && count[15:12] <= 4'd9));  // R3
  AST_DELAY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'd0 && !run_ctl && !ctl_wr && !cnt_wr) |=> ($stable(count) && $stable(wave_out)));  // R5
  AST_ONESHOT_START: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'd1 && armed && run_ctl && !rc_q && !ctl_wr) |=> (!wave_out && count == $past(init_q)));  // R6
  AST_RATE_ONE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'd2 && !wave_out && run_ctl && !ctl_wr) |=> wave_out);  // R7
  AST_STROBE_ONE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == 3'd4 || mode_q == 3'd5) && !wave_out && !ctl_wr && !cnt_wr) |=> wave_out);  // R9
endmodule

// File: tb/interval_counter_channel_test.sv
`timescale 1ns/1ps
module interval_counter_channel_test;
  logic        clk = 1'b0, rst_n = 1'b0, ctl_wr = 1'b0, ctl_bcd = 1'b0, cnt_wr = 1'b0, run_ctl = 1'b1;
  logic [2:0]  ctl_mode = 3'd0;
  logic [15:0] cnt_in = 16'd0;
  logic        wave_out;
  logic [15:0] count;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  interval_counter_channel uut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_mode(ctl_mode), .ctl_bcd(ctl_bcd),
    .cnt_wr(cnt_wr), .cnt_in(cnt_in), .run_ctl(run_ctl), .wave_out(wave_out), .count(count)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_ctl(input int m, input bit b);
    ctl_mode = 3'(m); ctl_bcd = b; ctl_wr = 1'b1;
    tick();
    ctl_wr = 1'b0;
  endtask

  task automatic load(input int n);
    cnt_in = 16'(n); cnt_wr = 1'b1;
    tick();
    cnt_wr = 1'b0;
  endtask

  task automatic measure_low(output int n);
    n = 0;
    while (wave_out == 1'b0 && n < 70000) begin
      n++;
      tick();
    end
  endtask

  task automatic pulse_rise();
    run_ctl = 1'b0; tick();
    run_ctl = 1'b1; tick();
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n;
    int highs;
    tick(); tick();
    check("R1 reset out", wave_out, 1);
    check("R1 reset count", count, 0);
    rst_n = 1'b1;
    tick();

    // R1: no counting before a count write
    set_ctl(0, 0);
    check("R1 ctl mode0 out", wave_out, 0);
    for (int i = 0; i < 5; i++) tick();
    check("R1 unarmed count", count, 0);
    check("R1 unarmed out", wave_out, 0);
    set_ctl(1, 0);
    for (int i = 0; i < 3; i++) pulse_rise();
    check("R1 unarmed trig out", wave_out, 1);
    check("R1 unarmed trig count", count, 0);

    // R5 / R2: delay sweep in binary
    run_ctl = 1'b1;
    for (int nn = 1; nn <= 8; nn++) begin
      set_ctl(0, 0);
      load(nn);
      check("R5 load out", wave_out, 0);
      check("R2 load count", count, nn);
      for (int j = 1; j <= nn + 1; j++) begin
        tick();
        check("R5 delay out", wave_out, (j >= nn) ? 1 : 0);
        check("R2 step", count, (nn - j) & 16'hFFFF);
      end
    end
    load(4); tick();
    run_ctl = 1'b0; tick(); tick();
    check("R5 hold count", count, 3);
    check("R5 hold out", wave_out, 0);
    run_ctl = 1'b1; tick(); tick();
    check("R5 resume low", wave_out, 0);
    tick();
    check("R5 resume high", wave_out, 1);
    load(0); tick();
    check("R2 zero wrap", count, 16'hFFFF);

    // R3: decimal stepping
    set_ctl(0, 1);
    load(0); tick();
    check("R3 0000 step", count, 16'h9999);
    load(16'h0100); tick();
    check("R3 0100 step", count, 16'h0099);
    tick();
    check("R3 0099 step", count, 16'h0098);
    load(16'h0010); tick();
    check("R3 0010 step", count, 16'h0009);
    load(3); tick(); tick();
    check("R3 bcd delay low", wave_out, 0);
    tick();
    check("R3 bcd delay high", wave_out, 1);

    // R7 / R4: rate sweep, plus alias 6
    for (int m = 0; m < 2; m++) begin
      for (int nn = 2; nn <= 9; nn++) begin
        set_ctl(m == 0 ? 2 : 6, 0);
        load(nn);
        check(m == 0 ? "R7 load out" : "R4 alias6 load out", wave_out, 1);
        for (int j = 1; j <= 3 * nn; j++) begin
          tick();
          check(m == 0 ? "R7 rate out" : "R4 alias6 out", wave_out, ((j % nn) != nn - 1) ? 1 : 0);
          check(m == 0 ? "R7 rate count" : "R4 alias6 count", count, nn - (j % nn));
        end
      end
    end
    set_ctl(2, 0);
    load(4); tick();
    cnt_in = 16'd6; cnt_wr = 1'b1; tick(); cnt_wr = 1'b0;
    for (int j = 3; j <= 12; j++) begin
      tick();
      check("R7 rewrite next period", wave_out, (j == 3 || j == 9) ? 0 : 1);
    end
    set_ctl(2, 0);
    load(5); tick();
    run_ctl = 1'b0; tick(); tick(); tick();
    check("R7 hold count", count, 4);
    check("R7 hold out", wave_out, 1);
    run_ctl = 1'b1;
    for (int j = 0; j < 4; j++) begin
      tick();
      check("R7 resume", wave_out, (j == 2) ? 0 : 1);
    end

    // R8 / R4: square sweep, plus alias 7
    for (int m = 0; m < 2; m++) begin
      for (int nn = 2; nn <= 11; nn++) begin
        set_ctl(m == 0 ? 3 : 7, 0);
        load(nn);
        for (int j = 0; j < 2 * nn; j++) begin
          if (j > 0) tick();
          check(m == 0 ? "R8 square out" : "R4 alias7 out", wave_out, ((j % nn) < (nn + 1) / 2) ? 1 : 0);
        end
      end
    end
    set_ctl(3, 1);
    load(16'h0010);
    for (int j = 0; j < 20; j++) begin
      if (j > 0) tick();
      check("R8 bcd ten", wave_out, ((j % 10) < 5) ? 1 : 0);
    end
    set_ctl(3, 1);
    load(0);
    highs = 0;
    for (int j = 0; j < 10000; j++) begin
      if (j > 0) tick();
      highs += int'(wave_out);
    end
    check("R8 bcd zero highs", highs, 5000);
    tick();
    check("R8 bcd zero reload", wave_out, 1);
    set_ctl(3, 0);
    load(0);
    highs = 0;
    for (int j = 0; j < 65536; j++) begin
      if (j > 0) tick();
      highs += int'(wave_out);
    end
    check("R8 bin zero highs", highs, 32768);
    tick();
    check("R8 bin zero reload out", wave_out, 1);
    check("R8 bin zero reload count", count, 0);

    // R6: one-shot
    for (int nn = 1; nn <= 6; nn++) begin
      set_ctl(1, 0);
      run_ctl = 1'b0;
      load(nn);
      check("R6 armed idle", wave_out, 1);
      run_ctl = 1'b1; tick();
      measure_low(n);
      check("R6 pulse width", n, nn);
    end
    pulse_rise();
    measure_low(n);
    check("R6 repeat no rewrite", n, 6);
    set_ctl(1, 0);
    run_ctl = 1'b0;
    load(5);
    run_ctl = 1'b1; tick(); tick();
    cnt_in = 16'd2; cnt_wr = 1'b1; tick(); cnt_wr = 1'b0;
    measure_low(n);
    check("R6 rewrite keeps pulse", n, 3);
    pulse_rise();
    measure_low(n);
    check("R6 new count next trigger", n, 2);
    load(4);
    pulse_rise();
    tick();
    run_ctl = 1'b0; tick();
    check("R6 mid pulse low", wave_out, 0);
    run_ctl = 1'b1; tick();
    measure_low(n);
    check("R6 retrigger restart", n, 4);

    // R9: software strobe ignores run_ctl
    run_ctl = 1'b0;
    for (int nn = 1; nn <= 6; nn++) begin
      set_ctl(4, 0);
      load(nn);
      check("R9 load out", wave_out, 1);
      for (int j = 1; j <= nn + 3; j++) begin
        tick();
        check("R9 strobe out", wave_out, (j == nn) ? 0 : 1);
      end
    end

    // R10: hardware strobe
    for (int nn = 1; nn <= 5; nn++) begin
      set_ctl(5, 0);
      run_ctl = 1'b0;
      load(nn);
      tick(); tick();
      check("R10 armed idle", wave_out, 1);
      for (int rep = 0; rep < 2; rep++) begin
        run_ctl = 1'b0; tick();
        run_ctl = 1'b1; tick();
        check("R10 trigger edge", wave_out, 1);
        for (int j = 1; j <= nn + 2; j++) begin
          tick();
          check("R10 strobe out", wave_out, (j == nn) ? 0 : 1);
        end
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule